// File: doc/BRIEF.md
# SMI Interval Timer Pair

This block sits inside a power-management register block and provides two independent countdown timers that request system-management interrupts. The short-interval timer runs in the millisecond range. The long-interval timer runs in the range of seconds. Both timers advance on a sub-millisecond strobe, `tick_i`, which arrives `SUB_PER_MS` times per millisecond. The long timer counts whole milliseconds, which it derives from that strobe.

Software uses a small write port with four targets: the SMI enable word, the SMI status word, and two configuration words that each carry one timer's period select. The current values come back on dedicated outputs. When a timer runs out, the block latches that timer's status bit and raises `smi_o` for one cycle. If the timer is still enabled, it starts counting a fresh full period. Any write to the enable word or to either configuration word re-evaluates both timers.

Parameters `HAS_SWSMI` and `HAS_PERIODIC` remove a timer entirely, together with its status write-mask bit.

Top module: `smi_timer_unit`

## Requirements
- R1: After reset the enable word, the status word, both period selects and `smi_o` are all zero, and no timer runs.
- R2: A write with `wr_sel_i`=0 stores all 16 bits of `wr_data_i` as the enable word. Bit 6 enables the short timer and bit 14 enables the long timer.
- R3: A write with `wr_sel_i`=2 sets the short-timer select from data bits 7:6. Select 0 gives a period of 1.5 ms. Select n>0 gives 8·2^n ms.
- R4: A write with `wr_sel_i`=3 sets the long-timer select from data bits 1:0. Select s gives a period of 8·2^(3−s) seconds, where one second is `MS_PER_SEC` milliseconds.
- R5: When a timer expires, its status bit (bit 6 for the short timer, bit 14 for the long timer) is set, the other status bit is left unchanged, and `smi_o` is high for exactly one cycle.
- R6: While a timer stays enabled, it expires again after every further full period.
- R7: A write to the enable word restarts every enabled timer from a full period. A timer whose enable bit is written to 0 stops at once and produces no further expiry.
- R8: A write to either configuration word restarts every enabled timer from a full period, using the newly written select.
- R9: A write with `wr_sel_i`=1 replaces only status bits 6 and 14 with the written data. All other status bits always read 0. An expiry in the same cycle as a status write wins, so the expiring timer's bit reads 1.
- R10: Expiries of both timers in the same cycle produce a single one-cycle pulse with both status bits set.
- R11: With a timer's feature parameter at 0, that timer never expires and its status bit cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Sub-millisecond strobe, `SUB_PER_MS` per ms |
| wr_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 enable, 1 status, 2 short-timer config, 3 long-timer config |
| wr_data_i | input | 16 | Write data |
| smi_en_o | output | 16 | Current enable word |
| smi_sts_o | output | 16 | Current status word |
| sw_rate_o | output | 2 | Current short-timer select |
| per_sel_o | output | 2 | Current long-timer select |
| smi_o | output | 1 | One-cycle SMI request pulse |

## Verification
The hardest case to reach is a status write that falls in the exact cycle in which a timer expires, because the write and the expiry then compete for the same bit. The bench arms the short timer at its 1.5 ms select with the strobe present on every cycle. This fixes the expiry edge at a known count after the enable write, and the bench issues a clearing status write aimed at that edge. It then checks that the bit still reads 1 and that the pulse occurs. A second instance built without the long timer receives the same stimulus, which shows at the ports that the absent timer's bit cannot be written and never fires.

// File: rtl/smi_tmr_pkg.sv
package smi_tmr_pkg;
  typedef enum logic [1:0] {
    TGT_ENABLE = 2'd0,
    TGT_STATUS = 2'd1,
    TGT_CFG_SW = 2'd2,
    TGT_CFG_PR = 2'd3
  } smi_tgt_e;

  localparam int SW_BIT  = 6;
  localparam int PER_BIT = 14;
  localparam int WORD_W  = 16;
endpackage

// File: rtl/smi_subdiv.sv
module smi_subdiv #(
  parameter int SUB_PER_MS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  output logic ms_step
);
  localparam int CW = (SUB_PER_MS > 1) ? $clog2(SUB_PER_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(SUB_PER_MS - 1);

  logic [CW-1:0] sub_cnt;

  assign ms_step = tick && (sub_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sub_cnt <= '0;
    end else if (tick) begin
      sub_cnt <= (sub_cnt == LAST) ? '0 : sub_cnt + 1'b1;
    end
  end

  AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    sub_cnt <= LAST); // R4
endmodule

// File: rtl/smi_countdown.sv
module smi_countdown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         arm,
  input  logic         halt,
  input  logic         step,
  input  logic [W-1:0] load,
  output logic         expire
);
  logic [W-1:0] cnt;
  logic         run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      run    <= 1'b0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (arm) begin
        cnt <= load;
        run <= 1'b1;
      end else if (halt) begin
        cnt <= '0;
        run <= 1'b0;
      end else if (run && step) begin
        if (cnt == W'(1)) begin
          cnt    <= load;
          expire <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  AST_LIVE_COUNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt != '0)); // R6
  AST_EXPIRE_ONLY_RUNNING: assert property (@(posedge clk) disable iff (rst)
    expire |-> run); // R7
endmodule

// File: rtl/smi_timer_unit.sv
module smi_timer_unit
  import smi_tmr_pkg::*;
#(
  parameter int SUB_PER_MS   = 2,
  parameter int MS_PER_SEC   = 1000,
  parameter bit HAS_SWSMI    = 1'b1,
  parameter bit HAS_PERIODIC = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick_i,
  input  logic        wr_i,
  input  logic [1:0]  wr_sel_i,
  input  logic [15:0] wr_data_i,
  output logic [15:0] smi_en_o,
  output logic [15:0] smi_sts_o,
  output logic [1:0]  sw_rate_o,
  output logic [1:0]  per_sel_o,
  output logic        smi_o
);
  localparam int SW_MAX = 64 * SUB_PER_MS;
  localparam int SW_W   = $clog2(SW_MAX + 1);
  localparam int PR_MAX = 64 * MS_PER_SEC;
  localparam int PR_W   = $clog2(PR_MAX + 1);
  localparam logic [WORD_W-1:0] STS_MASK =
    (HAS_SWSMI    ? (WORD_W'(1) << SW_BIT)  : '0) |
    (HAS_PERIODIC ? (WORD_W'(1) << PER_BIT) : '0);

  logic [WORD_W-1:0] en_q, sts_q, en_nxt, exp_vec;
  logic [1:0]        rate_q, per_q, rate_nxt, per_nxt;
  logic              smi_q, touch, sts_wr;
  logic              arm_sw, halt_sw, arm_pr, halt_pr;
  logic              exp_sw, exp_pr;
  logic [SW_W-1:0]   sw_load;
  logic [PR_W-1:0]   pr_load;

  always_comb begin
    en_nxt   = (wr_i && wr_sel_i == TGT_ENABLE) ? wr_data_i : en_q;
    rate_nxt = (wr_i && wr_sel_i == TGT_CFG_SW) ? wr_data_i[7:6] : rate_q;
    per_nxt  = (wr_i && wr_sel_i == TGT_CFG_PR) ? wr_data_i[1:0] : per_q;
    sts_wr   = wr_i && (wr_sel_i == TGT_STATUS);
    touch    = wr_i && (wr_sel_i != TGT_STATUS);
    arm_sw   = touch &&  en_nxt[SW_BIT];
    halt_sw  = touch && !en_nxt[SW_BIT];
    arm_pr   = touch &&  en_nxt[PER_BIT];
    halt_pr  = touch && !en_nxt[PER_BIT];
    if (rate_nxt == 2'd0) sw_load = SW_W'((3 * SUB_PER_MS) / 2);
    else                  sw_load = SW_W'((8 << rate_nxt) * SUB_PER_MS);
    pr_load = PR_W'((8 << (2'd3 - per_nxt)) * MS_PER_SEC);
    exp_vec          = '0;
    exp_vec[SW_BIT]  = exp_sw;
    exp_vec[PER_BIT] = exp_pr;
  end

  generate
    if (HAS_SWSMI) begin : g_sw
      smi_countdown #(.W(SW_W)) u_sw (
        .clk(clk), .rst(rst), .arm(arm_sw), .halt(halt_sw),
        .step(tick_i), .load(sw_load), .expire(exp_sw));
    end else begin : g_no_sw
      assign exp_sw = 1'b0;
    end

    if (HAS_PERIODIC) begin : g_pr
      logic ms_step;
      smi_subdiv #(.SUB_PER_MS(SUB_PER_MS)) u_div (
        .clk(clk), .rst(rst), .clr(arm_pr), .tick(tick_i), .ms_step(ms_step));
      smi_countdown #(.W(PR_W)) u_pr (
        .clk(clk), .rst(rst), .arm(arm_pr), .halt(halt_pr),
        .step(ms_step), .load(pr_load), .expire(exp_pr));
    end else begin : g_no_pr
      assign exp_pr = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      sts_q  <= '0;
      rate_q <= '0;
      per_q  <= '0;
      smi_q  <= 1'b0;
    end else begin
      en_q   <= en_nxt;
      rate_q <= rate_nxt;
      per_q  <= per_nxt;
      sts_q  <= (sts_wr ? (wr_data_i & STS_MASK) : sts_q) | (exp_vec & STS_MASK);
      smi_q  <= exp_sw | exp_pr;
    end
  end

  assign smi_en_o  = en_q;
  assign smi_sts_o = sts_q;
  assign sw_rate_o = rate_q;
  assign per_sel_o = per_q;
  assign smi_o     = smi_q;

  AST_PULSE_HAS_STATUS: assert property (@(posedge clk) disable iff (rst)
    smi_q |-> ((sts_q & STS_MASK) != '0)); // R5
  AST_SW_EXPIRE_ENABLED: assert property (@(posedge clk) disable iff (rst)
    exp_sw |-> en_q[SW_BIT]); // R7
  AST_PR_EXPIRE_ENABLED: assert property (@(posedge clk) disable iff (rst)
    exp_pr |-> en_q[PER_BIT]); // R7
  AST_ARM_QUIETS_SW: assert property (@(posedge clk) disable iff (rst)
    arm_sw |=> !exp_sw); // R8
endmodule

// File: tb/sim_smi_timer_unit.sv
module sim_smi_timer_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b1;
  logic        wr = 1'b0;
  logic [1:0]  wsel = '0;
  logic [15:0] wdata = '0;
  logic [15:0] en0, sts0, en1, sts1;
  logic [1:0]  rate0, per0, rate1, per1;
  logic        smi0, smi1;

  int errors = 0;
  int checks = 0;
  int u1_pulses = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smi_timer_unit #(.SUB_PER_MS(2), .MS_PER_SEC(2)) u0 (
    .clk(clk), .rst(rst), .tick_i(tick), .wr_i(wr), .wr_sel_i(wsel),
    .wr_data_i(wdata), .smi_en_o(en0), .smi_sts_o(sts0),
    .sw_rate_o(rate0), .per_sel_o(per0), .smi_o(smi0));

  smi_timer_unit #(.SUB_PER_MS(2), .MS_PER_SEC(2), .HAS_PERIODIC(1'b0)) u1 (
    .clk(clk), .rst(rst), .tick_i(tick), .wr_i(wr), .wr_sel_i(wsel),
    .wr_data_i(wdata), .smi_en_o(en1), .smi_sts_o(sts1),
    .sw_rate_o(rate1), .per_sel_o(per1), .smi_o(smi1));

  always @(posedge clk) if (smi1) u1_pulses++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr = 1'b1; wsel = sel; wdata = d;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic wait_pulse(input int limit, output int k);
    k = -1;
    for (int i = 1; i <= limit; i++) begin
      @(posedge clk); #1;
      if (smi0) begin k = i; break; end
    end
  endtask

  task automatic quiesce();
    wr_reg(2'd0, 16'h0000);
    wr_reg(2'd1, 16'h0000);
  endtask

  task automatic t_reset();
    check("R1 enable", en0, 0);
    check("R1 status", sts0, 0);
    check("R1 rate", rate0, 0);
    check("R1 persel", per0, 0);
    check("R1 smi", smi0, 0);
  endtask

  task automatic t_enreg();
    wr_reg(2'd0, 16'hA5A5);
    check("R2 enable readback", en0, 16'hA5A5);
    repeat (300) @(posedge clk);
    #1 check("R2 no timer from other bits", sts0, 0);
    quiesce();
  endtask

  task automatic t_sw_short();
    int k;
    wr_reg(2'd2, 16'h0000);
    wr_reg(2'd0, 16'h0040);
    wait_pulse(50, k);
    check("R3 1.5ms delay", k, 4);
    check("R5 short status", sts0, 16'h0040);
    @(posedge clk); #1;
    check("R5 pulse one cycle", smi0, 0);
    wait_pulse(50, k);
    check("R6 rearm interval", k, 2);
    quiesce();
  endtask

  task automatic t_sw_rates();
    int k;
    for (int n = 1; n <= 3; n++) begin
      wr_reg(2'd2, 16'(n << 6));
      check("R3 rate readback", rate0, n);
      wr_reg(2'd0, 16'h0040);
      wait_pulse(400, k);
      check("R3 doubling period", k, 16 * (1 << n) + 1);
      quiesce();
    end
  endtask

  task automatic t_periodic();
    int k;
    int base;
    base = u1_pulses;
    wr_reg(2'd3, 16'h0003);
    wr_reg(2'd0, 16'h4000);
    wait_pulse(100, k);
    check("R4 select 3 period", k, 33);
    check("R5 long status", sts0, 16'h4000);
    wait_pulse(100, k);
    check("R6 long rearm interval", k, 32);
    quiesce();
    wr_reg(2'd3, 16'h0000);
    check("R4 select readback", per0, 0);
    wr_reg(2'd0, 16'h4000);
    wait_pulse(600, k);
    check("R4 select 0 period", k, 257);
    check("R11 absent timer never fires", u1_pulses - base, 0);
    check("R11 absent status bit", sts1, 0);
    quiesce();
  endtask

  task automatic t_restart();
    int k;
    wr_reg(2'd2, 16'h0040);
    wr_reg(2'd0, 16'h0040);
    repeat (20) @(posedge clk);
    wr_reg(2'd0, 16'h0040);
    wait_pulse(100, k);
    check("R7 enable write restarts", k, 33);
    repeat (10) @(posedge clk);
    wr_reg(2'd2, 16'h0040);
    wait_pulse(100, k);
    check("R8 config write restarts", k, 33);
    wr_reg(2'd1, 16'h0000);
    repeat (20) @(posedge clk);
    wr_reg(2'd3, 16'h0002);
    wait_pulse(100, k);
    check("R8 other config word restarts", k, 33);
    repeat (10) @(posedge clk);
    wr_reg(2'd0, 16'h0000);
    wr_reg(2'd1, 16'h0000);
    wait_pulse(200, k);
    check("R7 disabled stops", k, -1);
    check("R7 no status after stop", sts0, 0);
  endtask

  task automatic t_status();
    wr_reg(2'd1, 16'hFFFF);
    check("R9 masked write", sts0, 16'h4040);
    check("R11 mask drops absent bit", sts1, 16'h0040);
    wr_reg(2'd1, 16'h4000);
    check("R9 bit replace", sts0, 16'h4000);
    wr_reg(2'd1, 16'h0000);
    check("R9 clear", sts0, 0);
    wr_reg(2'd2, 16'h0000);
    wr_reg(2'd0, 16'h0040);
    repeat (3) @(posedge clk);
    wr_reg(2'd1, 16'h0000);
    check("R9 expiry beats write", sts0, 16'h0040);
    check("R9 pulse on race", smi0, 1);
    quiesce();
  endtask

  task automatic t_both();
    int k;
    wr_reg(2'd2, 16'h0040);
    wr_reg(2'd3, 16'h0003);
    wr_reg(2'd1, 16'h4000);
    wr_reg(2'd0, 16'h4040);
    check("R5 other bit kept before expiry", sts0, 16'h4000);
    wr_reg(2'd1, 16'h0000);
    wr_reg(2'd0, 16'h4040);
    wait_pulse(100, k);
    check("R10 joint expiry time", k, 33);
    check("R10 both status bits", sts0, 16'h4040);
    @(posedge clk); #1;
    check("R10 single pulse", smi0, 0);
    quiesce();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_enreg();
    t_sw_short();
    t_sw_rates();
    t_periodic();
    t_restart();
    t_status();
    t_both();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule